// File: doc/BRIEF.md
# Space-Vector Dwell Time Calculator

This block takes a reference voltage vector for a three-phase inverter and works out how long each vector should be applied in one switching period. The reference is given as a modulation index and a phase angle. For each request the block returns the sector that holds the reference and three dwell counts in clock ticks. T1 is the time on the leading active vector of the sector, T2 is the time on the trailing active vector, and T0 is the zero-vector time that a downstream sequencer splits between the all-off and all-on states.

The work runs in a fixed order. First the phase word is split into a sector number and an in-sector angle α between 0 and 60 degrees. Next the two active times are formed from sin(α) and sin(60°−α), each scaled by the index and by the period. A volt-second balance gives T2 = m·T·sin(α) and T1 = m·T·sin(60°−α). Last, T0 is whatever remains of the period. Full-scale index is the edge of the linear region, where the peak phase voltage is Vdc/√3. The sine values come from a constant table of 65 points over 0–60 degrees. The table is built at elaboration time, and one table serves both angles.

A request is one cycle of `in_valid`. Its result appears with one cycle of `out_valid` a fixed number of cycles later. The usual host keeps one request in flight, but the pipeline also accepts a request on every cycle.

Top module: `svm_dwell_calc`

## Requirements
- R1: While `rst_n` is low, and after it rises until the first result, `out_valid` is 0 and `out_sector`, `out_t1`, `out_t2` and `out_t0` are 0.
- R2: `out_sector` equals floor(`in_phase`·6 / 2^PHASE_W), so it is in the range 0–5, where sector k covers phases from k·60° up to but not including (k+1)·60°.
- R3: The angle index i is bits [PHASE_W-1 : PHASE_W-ANG_W] of the remainder (`in_phase`·6 mod 2^PHASE_W). The table entry S(k) equals round(sin(k·60°/2^ANG_W)·2^FRAC_W) for k = 0 … 2^ANG_W.
- R4: `out_t2` = floor((`in_mod`·PERIOD·S(i) + 2^(MOD_W+FRAC_W−1)) / 2^(MOD_W+FRAC_W)), which is round-half-up of m·T·sin(α), with m = `in_mod`/2^MOD_W.
- R5: `out_t1` is formed in the same way as R4, but from S(2^ANG_W − i), that is, from sin(60°−α).
- R6: `out_t0` = PERIOD − `out_t1` − `out_t2`, so the three counts always add up to exactly PERIOD.
- R7: A request captured on a rising edge with `in_valid` high gives `out_valid` high for one cycle after the second rising edge that follows. Requests on consecutive cycles give results on consecutive cycles, in the same order.
- R8: While `out_valid` is low, the sector and the three counts hold the values of the last result.
- R9: A modulation index of 0 gives `out_t1` = `out_t2` = 0 and `out_t0` = PERIOD. At phase 0 the trailing time is 0 and the whole active time falls on T1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| in_mod | input | MOD_W | Modulation index as an unsigned fraction |
| in_phase | input | PHASE_W | Reference angle; full range is one turn |
| out_valid | output | 1 | Result strobe |
| out_sector | output | 3 | Sector number 0–5 |
| out_t1 | output | CNT_W | Leading active vector dwell, in clocks |
| out_t2 | output | CNT_W | Trailing active vector dwell, in clocks |
| out_t0 | output | CNT_W | Zero vector dwell, in clocks |

## Verification
A bad sector split or angle index shows up in the very first result it touches. The sector number is wrong, or T1 and T2 are swapped or shifted along the sine curve, and this is visible two edges after capture. A wrong table entry only shows up at the angles that use that entry, so the stimulus sweeps phases across every sector and also lands on sector edges, at the sector mid-point and at the top of the phase range. Pipeline faults, such as a stale stage, a lost strobe or data that does not hold between results, show at the ports on the same cycle as the result they break. The reference model checks every cycle, including bursts of requests sent back to back.

// File: rtl/svm_dwell_calc.sv
module svm_dwell_calc #(
  parameter int PHASE_W = 16,
  parameter int MOD_W   = 12,
  parameter int ANG_W   = 6,
  parameter int FRAC_W  = 14,
  parameter int CNT_W   = 16,
  parameter int PERIOD  = 2000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [MOD_W-1:0]   in_mod,
  input  logic [PHASE_W-1:0] in_phase,
  output logic               out_valid,
  output logic [2:0]         out_sector,
  output logic [CNT_W-1:0]   out_t1,
  output logic [CNT_W-1:0]   out_t2,
  output logic [CNT_W-1:0]   out_t0
);
  localparam int N    = 1 << ANG_W;
  localparam int LW   = FRAC_W + 1;
  localparam int SH   = MOD_W + FRAC_W;
  localparam int PRW  = MOD_W + LW + CNT_W;
  localparam int DROP = PHASE_W - ANG_W;

  function automatic logic [LW-1:0] sin_q(input int k);
    real a;
    a = 3.141592653589793 * real'(k) / (3.0 * real'(N));
    return LW'(longint'($sin(a) * real'(longint'(1) << FRAC_W)));
  endfunction

  function automatic logic [CNT_W-1:0] scale(input logic [MOD_W-1:0] m, input logic [LW-1:0] s);
    logic [PRW-1:0] p;
    p = PRW'(m) * PRW'(s) * PRW'(PERIOD);
    return CNT_W'((p + (PRW'(1) << (SH - 1))) >> SH);
  endfunction

  logic [LW-1:0] lut [0:N];
  for (genvar k = 0; k <= N; k++) begin : g_lut
    assign lut[k] = sin_q(k);
  end

  logic [ANG_W+2:0] split;
  assign split = (ANG_W+3)'(({3'b0, in_phase} * (PHASE_W+3)'(6)) >> DROP);

  logic             v1, v2;
  logic [2:0]       s1_sec, s2_sec;
  logic [ANG_W:0]   s1_idx;
  logic [MOD_W-1:0] s1_mod;
  logic [CNT_W-1:0] s2_t1, s2_t2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      out_valid <= 1'b0;
      s1_sec <= '0; s1_idx <= '0; s1_mod <= '0;
      s2_sec <= '0; s2_t1 <= '0; s2_t2 <= '0;
      out_sector <= '0; out_t1 <= '0; out_t2 <= '0; out_t0 <= '0;
    end else begin
      v1 <= in_valid;
      v2 <= v1;
      out_valid <= v2;
      if (in_valid) begin
        s1_sec <= split[ANG_W+2:ANG_W];
        s1_idx <= {1'b0, split[ANG_W-1:0]};
        s1_mod <= in_mod;
      end
      if (v1) begin
        s2_sec <= s1_sec;
        s2_t2  <= scale(s1_mod, lut[s1_idx]);
        s2_t1  <= scale(s1_mod, lut[(ANG_W+1)'(N) - s1_idx]);
      end
      if (v2) begin
        out_sector <= s2_sec;
        out_t1 <= s2_t1;
        out_t2 <= s2_t2;
        out_t0 <= CNT_W'(PERIOD) - s2_t1 - s2_t2;
      end
    end
  end

  AST_ACTIVE_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    v2 |-> ({1'b0, s2_t1} + {1'b0, s2_t2} <= (CNT_W+1)'(PERIOD))); // R6
  AST_SECTOR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_sector <= 3'd5); // R2
  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##3 out_valid); // R7
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 3)); // R7
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !v2 |=> $stable({out_sector, out_t1, out_t2, out_t0})); // R8
  AST_ZERO_MOD: assert property (@(posedge clk) disable iff (!rst_n)
    (v1 && s1_mod == '0) |=> (s2_t1 == '0 && s2_t2 == '0)); // R9
endmodule

// File: tb/svm_dwell_calc_tb_top.sv
module svm_dwell_calc_tb_top;
  localparam int PERIOD = 2000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [11:0] in_mod = '0;
  logic [15:0] in_phase = '0;
  logic        out_valid;
  logic [2:0]  out_sector;
  logic [15:0] out_t1, out_t2, out_t0;

  always #2.5 clk = ~clk;

  svm_dwell_calc dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mod(in_mod), .in_phase(in_phase),
    .out_valid(out_valid), .out_sector(out_sector), .out_t1(out_t1), .out_t2(out_t2), .out_t0(out_t0)
  );

  typedef struct { bit v; bit zm; int sec; int t1; int t2; int t0; } exp_t;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;
  exp_t pipe[$];
  exp_t last;

  function automatic longint sinq(int k);
    return longint'($sin(3.141592653589793 * real'(k) / 192.0) * 16384.0);
  endfunction

  function automatic exp_t model(bit v, int unsigned ph, int unsigned md);
    exp_t e;
    longint p6, rem, idx;
    p6  = longint'(ph) * 6;
    rem = p6 % 65536;
    idx = rem / 1024;
    e.v   = v;
    e.zm  = (md == 0);
    e.sec = int'(p6 / 65536);
    e.t2  = int'((longint'(md) * PERIOD * sinq(int'(idx)) + 33554432) / 67108864);
    e.t1  = int'((longint'(md) * PERIOD * sinq(64 - int'(idx)) + 33554432) / 67108864);
    e.t0  = PERIOD - e.t1 - e.t2;
    return e;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    #1;
    if (!done) begin
      if (!rst_n) begin
        chk("R1 out_valid in reset", out_valid, 0);
        chk("R1 counts in reset", int'(out_t1) + int'(out_t2) + int'(out_t0) + int'(out_sector), 0);
        pipe.delete();
        pipe.push_back('{0, 0, 0, 0, 0, 0});
        pipe.push_back('{0, 0, 0, 0, 0, 0});
        last = '{0, 0, 0, 0, 0, 0};
      end else begin
        exp_t e;
        e = pipe.pop_front();
        chk("R7 out_valid timing", out_valid, e.v);
        if (e.v) begin
          chk("R2 sector", out_sector, e.sec);
          chk(e.zm ? "R9 R3 R4 t2" : "R3 R4 t2", out_t2, e.t2);
          chk(e.zm ? "R9 R5 t1" : "R5 t1", out_t1, e.t1);
          chk("R6 t0", out_t0, e.t0);
          last = e;
        end else begin
          chk("R8 R1 hold sector", out_sector, last.sec);
          chk("R8 R1 hold counts", int'(out_t1) + 65536 * int'(out_t2), last.t1 + 65536 * last.t2);
          chk("R8 R1 hold t0", out_t0, last.t0);
        end
        pipe.push_back(model(in_valid, in_phase, in_mod));
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  task automatic req(input int ph, input int md, input int gap);
    @(negedge clk);
    in_valid = 1'b1; in_phase = 16'(ph); in_mod = 12'(md);
    @(negedge clk);
    in_valid = 1'b0;
    in_phase = 16'(ph ^ 16'h5a5a); in_mod = 12'(md ^ 12'h3c3);
    repeat (gap) @(negedge clk);
  endtask

  initial begin
    int unsigned lcg;
    lcg = 32'h1234_5678;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    req(0, 4095, 4);
    req(0, 0, 4);
    req(12345, 0, 4);
    req(5461, 4095, 4);
    req(10922, 2048, 4);
    req(10923, 2048, 4);
    req(21846, 3000, 4);
    req(32768, 4095, 4);
    req(43690, 1000, 4);
    req(54613, 4095, 4);
    req(65535, 4095, 4);
    req(60000, 1, 4);
    for (int s = 0; s < 6; s++) req(s * 10923 + 777, 1234 + s * 400, 3);
    @(negedge clk);
    for (int n = 0; n < 40; n++) begin
      lcg = lcg * 1103515245 + 12345;
      in_valid = 1'b1;
      in_phase = lcg[31:16];
      in_mod = lcg[11:0];
      @(negedge clk);
    end
    in_valid = 1'b0;
    for (int n = 0; n < 60; n++) begin
      lcg = lcg * 1103515245 + 12345;
      req(int'(lcg[31:16]), int'(lcg[13:2]), int'(lcg[1:0]));
    end
    repeat (8) @(negedge clk);
    done = 1'b1;
    finish_run();
  end
endmodule